// File: doc/BRIEF.md
# Slew-Limited Pressure Regulator

This block closes the pressure loop of a blower-driven breathing circuit. Each time a new pressure reading arrives, marked by a one-cycle valid strobe, the block compares it with the target pressure. It then moves a registered motor duty word one fixed step in the direction that corrects the error. The duty word goes straight to a PWM generator.

Because the duty never changes by more than one step per reading, the airflow delivered to the patient ramps smoothly and never surges. Two limits bound the duty. The lower one is the minimum duty at which the motor still turns, since a duty below it only heats the winding. The upper one is the full-scale value.

When the enable is low, the block parks the duty at a start value. It reloads that same value on reset, so the loop always restarts from a known output.

Top module: `slew_regulator`

## Requirements
- R1: While reset is high at a clock edge, the duty output takes the start value `DUTY_INIT` at that edge.
- R2: When enabled and strobed with the measured pressure below the target, the duty rises by exactly `STEP` at the next edge, provided it stays at or below `DUTY_MAX`.
- R3: When enabled and strobed with the measured pressure above the target, the duty falls by exactly `STEP` at the next edge, provided it stays at or above `DUTY_MIN`.
- R4: When enabled and strobed with the measured pressure equal to the target, the duty is unchanged.
- R5: A rise that would pass `DUTY_MAX` stops at `DUTY_MAX` and never wraps to a small value.
- R6: A fall that would pass `DUTY_MIN` (the motor stall threshold) stops at `DUTY_MIN`, so the duty is never below it.
- R7: When enabled with no strobe, the duty is unchanged, whatever the pressure and target inputs are.
- R8: When enable is low at an edge, the duty becomes `DUTY_INIT` at that edge, and the strobe and pressure inputs have no effect.
- R9: Between two consecutive edges outside reset, the duty never changes by more than `STEP` while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Loop enable; low parks the duty at the start value |
| smp_vld_i | input | 1 | One-cycle strobe marking a new pressure reading |
| pres_i | input | PRES_W | Measured pressure, unsigned |
| target_i | input | PRES_W | Target pressure, unsigned |
| duty_o | output | DUTY_W | Registered motor duty word |

## Verification
The assertions assume that the parameters are consistent, with `STEP` greater than zero and `DUTY_MIN <= DUTY_INIT <= DUTY_MAX` less than 2^DUTY_W. They also assume that reset is high from the first edge and that the inputs are settled at each rising edge. The bench meets these assumptions by using a small configuration whose start value lies inside the limits. It holds reset from time zero and changes every input only on the falling clock edge. The bench then sweeps every pressure and target pair of a three-bit reading from several starting duties. It also drives long one-way runs that pin the duty against both limits.

// File: rtl/slew_reg_pkg.sv
package slew_reg_pkg;

    // Direction of the pressure error for one reading
    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_LOW  = 2'd1,   // pressure under target: push duty up
        ERR_HIGH = 2'd2    // pressure over target: pull duty down
    } err_dir_e;

    // Update request handed from the error sensor to the duty register
    typedef struct packed {
        logic     go;
        err_dir_e dir;
    } step_req_t;

    function automatic err_dir_e classify(input int unsigned meas,
                                          input int unsigned tgt);
        if (meas < tgt)      return ERR_LOW;
        else if (meas > tgt) return ERR_HIGH;
        else                 return ERR_NONE;
    endfunction

    function automatic int unsigned clamp_range(input int unsigned v,
                                                input int unsigned lo,
                                                input int unsigned hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/slew_err_sense.sv
module slew_err_sense
    import slew_reg_pkg::*;
#(
    parameter int PRES_W = 12
) (
    input  logic              en_i,
    input  logic              smp_vld_i,
    input  logic [PRES_W-1:0] pres_i,
    input  logic [PRES_W-1:0] target_i,
    output step_req_t         req_o
);
    always_comb begin
        req_o.go  = en_i & smp_vld_i;
        req_o.dir = classify(32'(pres_i), 32'(target_i));
    end
endmodule

// File: rtl/slew_duty_step.sv
module slew_duty_step
    import slew_reg_pkg::*;
#(
    parameter int DUTY_W   = 12,
    parameter int STEP     = 16,
    parameter int DUTY_MIN = 400,
    parameter int DUTY_MAX = 4095
) (
    input  err_dir_e          dir_i,
    input  logic [DUTY_W-1:0] cur_i,
    output logic [DUTY_W-1:0] nxt_o
);
    // One extra bit so sums and differences never wrap
    localparam int XW = DUTY_W + 1;
    localparam logic [XW-1:0] STEP_X = XW'(STEP);
    localparam logic [XW-1:0] MIN_X  = XW'(DUTY_MIN);
    localparam logic [XW-1:0] MAX_X  = XW'(DUTY_MAX);

    logic [XW-1:0] cur_x, room_up, room_dn, res_x;

    always_comb begin
        cur_x   = {1'b0, cur_i};
        room_up = (cur_x >= MAX_X) ? '0 : (MAX_X - cur_x);
        room_dn = (cur_x <= MIN_X) ? '0 : (cur_x - MIN_X);
        unique case (dir_i)
            ERR_LOW:  res_x = (room_up < STEP_X) ? MAX_X : (cur_x + STEP_X);
            ERR_HIGH: res_x = (room_dn < STEP_X) ? MIN_X : (cur_x - STEP_X);
            default:  res_x = cur_x;
        endcase
        nxt_o = res_x[DUTY_W-1:0];
    end
endmodule

// File: rtl/slew_regulator.sv
module slew_regulator
    import slew_reg_pkg::*;
#(
    parameter int DUTY_W    = 12,
    parameter int PRES_W    = 12,
    parameter int STEP      = 16,
    parameter int DUTY_MIN  = 400,
    parameter int DUTY_MAX  = 4095,
    parameter int DUTY_INIT = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              smp_vld_i,
    input  logic [PRES_W-1:0] pres_i,
    input  logic [PRES_W-1:0] target_i,
    output logic [DUTY_W-1:0] duty_o
);
    // Start value forced inside the legal band
    localparam int unsigned INIT_EFF =
        clamp_range(DUTY_INIT, DUTY_MIN, DUTY_MAX);
    localparam logic [DUTY_W-1:0] INIT_VAL = DUTY_W'(INIT_EFF);

    step_req_t         req;
    logic [DUTY_W-1:0] duty_q, duty_nxt;

    slew_err_sense #(.PRES_W(PRES_W)) u_sense (
        .en_i      (en_i),
        .smp_vld_i (smp_vld_i),
        .pres_i    (pres_i),
        .target_i  (target_i),
        .req_o     (req)
    );

    slew_duty_step #(
        .DUTY_W   (DUTY_W),
        .STEP     (STEP),
        .DUTY_MIN (DUTY_MIN),
        .DUTY_MAX (DUTY_MAX)
    ) u_step (
        .dir_i (req.dir),
        .cur_i (duty_q),
        .nxt_o (duty_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            duty_q <= INIT_VAL;
        end else if (req.go) begin
            duty_q <= duty_nxt;
        end
    end

    assign duty_o = duty_q;
endmodule

// File: rtl/slew_regulator_chk.sv
module slew_regulator_chk #(
    parameter int DUTY_W    = 12,
    parameter int PRES_W    = 12,
    parameter int STEP      = 16,
    parameter int DUTY_MIN  = 400,
    parameter int DUTY_MAX  = 4095,
    parameter int DUTY_INIT = 400
) (
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic              smp_vld_i,
    input logic [PRES_W-1:0] pres_i,
    input logic [PRES_W-1:0] target_i,
    input logic [DUTY_W-1:0] duty_o
);
    // R2: a low reading moves the duty up, unless it is already at the top
    a_r2_raise: assert property (@(posedge clk) disable iff (rst)
        (en_i && smp_vld_i && pres_i < target_i) |=>
            (duty_o > $past(duty_o) || int'(duty_o) == DUTY_MAX));

    // R3: a high reading moves the duty down, unless it is already at the floor
    a_r3_lower: assert property (@(posedge clk) disable iff (rst)
        (en_i && smp_vld_i && pres_i > target_i) |=>
            (duty_o < $past(duty_o) || int'(duty_o) == DUTY_MIN));

    // R4: a matching reading leaves the duty alone
    a_r4_hold_on_match: assert property (@(posedge clk) disable iff (rst)
        (en_i && smp_vld_i && pres_i == target_i) |=> $stable(duty_o));

    // R5, R6: the duty stays inside the band
    a_r5_r6_band: assert property (@(posedge clk) disable iff (rst)
        (int'(duty_o) >= DUTY_MIN && int'(duty_o) <= DUTY_MAX));

    // R7: without a strobe nothing moves
    a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (en_i && !smp_vld_i) |=> $stable(duty_o));

    // R8: a disabled loop parks at the start value
    a_r8_disabled_park: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> int'(duty_o) == DUTY_INIT);

    // R9: one update never moves the duty by more than one step
    a_r9_step_bound: assert property (@(posedge clk) disable iff (rst)
        en_i |=> ((int'(duty_o) - int'($past(duty_o)) <= STEP) &&
                  (int'($past(duty_o)) - int'(duty_o) <= STEP)));
endmodule

bind slew_regulator slew_regulator_chk #(
    .DUTY_W    (DUTY_W),
    .PRES_W    (PRES_W),
    .STEP      (STEP),
    .DUTY_MIN  (DUTY_MIN),
    .DUTY_MAX  (DUTY_MAX),
    .DUTY_INIT (DUTY_INIT)
) u_slew_chk (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .smp_vld_i (smp_vld_i),
    .pres_i    (pres_i),
    .target_i  (target_i),
    .duty_o    (duty_o)
);

// File: tb/test_slew_regulator.sv
module test_slew_regulator;
    localparam int DW = 8, PW = 3, STP = 7, DMIN = 30, DMAX = 200, DINIT = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          vld = 1'b0;
    logic [PW-1:0] pres = '0;
    logic [PW-1:0] tgt = '0;
    logic [DW-1:0] duty;

    int n_run = 0, n_fail = 0, model = DINIT, cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    slew_regulator #(
        .DUTY_W(DW), .PRES_W(PW), .STEP(STP),
        .DUTY_MIN(DMIN), .DUTY_MAX(DMAX), .DUTY_INIT(DINIT)
    ) i_slew_regulator (
        .clk(clk), .rst(rst), .en_i(en), .smp_vld_i(vld),
        .pres_i(pres), .target_i(tgt), .duty_o(duty)
    );

    task automatic check(input string req, input int exp);
        n_run++;
        if (int'(duty) != exp) begin
            n_fail++;
            $display("FAIL %s: duty=%0d expected=%0d", req, duty, exp);
        end
    endtask

    // Drive one cycle of inputs, update the model, check after the edge
    task automatic step(input bit e, input bit v, input int p, input int s);
        string req;
        @(negedge clk);
        en = e; vld = v; pres = PW'(p); tgt = PW'(s);
        if (!e) begin
            model = DINIT; req = "R8";
        end else if (!v) begin
            req = "R7";
        end else if (p < s) begin
            req = (model + STP > DMAX) ? "R5" : "R2";
            model = (model + STP > DMAX) ? DMAX : model + STP;
        end else if (p > s) begin
            req = (model - STP < DMIN) ? "R6" : "R3";
            model = (model - STP < DMIN) ? DMIN : model - STP;
        end else begin
            req = "R4";
        end
        @(negedge clk);
        vld = 1'b0;
        check(req, model);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_fail++;
                $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", DINIT);
        @(negedge clk);
        rst = 1'b0;
        en = 1'b1;
        @(negedge clk);
        check("R1", DINIT);

        // R2 R3 R4: exhaustive pressure/target sweep from several start points
        for (int rep = 0; rep < 3; rep++) begin
            for (int p = 0; p < 8; p++)
                for (int s = 0; s < 8; s++)
                    step(1'b1, 1'b1, p, s);
            for (int k = 0; k < 4 * rep + 1; k++) step(1'b1, 1'b1, 0, 7);
        end

        // R5: long run upward pins at the ceiling
        for (int k = 0; k < 30; k++) step(1'b1, 1'b1, 1, 6);
        // R7: no strobe, inputs changing
        for (int p = 0; p < 8; p++)
            for (int s = 0; s < 8; s++)
                step(1'b1, 1'b0, p, s);
        // R6: long run downward pins at the floor
        for (int k = 0; k < 30; k++) step(1'b1, 1'b1, 7, 2);
        // R7 at the floor
        step(1'b1, 1'b0, 7, 0);

        // R8: disable with strobe and errors present parks at start value
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 0, 5);
        step(1'b0, 1'b1, 0, 7);
        step(1'b0, 1'b1, 7, 0);
        step(1'b1, 1'b1, 3, 3);
        step(1'b1, 1'b1, 2, 3);

        // R1: reset in mid-run restores the start value
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 0, 4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        model = DINIT;
        check("R1", DINIT);
        rst = 1'b0;

        // R9: alternating directions, each move bounded by one step
        for (int k = 0; k < 40; k++) step(1'b1, 1'b1, k % 2 ? 1 : 6, 4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule